// File: doc/BRIEF.md
# Per-Channel Gamma Lookup with Indirect Table Load

This block corrects an RGB pixel stream of 8 bits per colour through three 10-bit lookup tables: one for red, one for green, one for blue. Each table has 256 entries. Every pixel accepted on the input leaves the block one clock later. Each colour is either replaced by its table entry or, with correction off, widened by appending two zero bits.

Software fills the tables through three registers: a control/status word, an address word and a data word. The address word holds the start index, a one-hot (or multi-hot) colour selection, an auto-advance flag and a read request. Each accepted data word is committed to the table on the following clock. While that commit is in flight, the block refuses further data and address writes and shows this through two ready flags. A normal load clears correction, writes the address, streams 256 data words and enables correction again.

Top module: `gamma_lut_port`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0x0030 (only the address-ready bit 5 and the write-ready bit 4 set), the address word reads 0, and the output valid is low.
- R2: Control word, register select 0: bit 0 enables correction, bit 1 and bit 2 are plain read/write storage, bit 3 is read-ready, bit 4 is write-ready and bit 5 is address-ready. Bits 3 to 5 ignore writes.
- R3: Address word, register select 2: bits 7:0 hold the index, bit 8 selects blue, bit 9 selects green, bit 10 selects red, bit 11 enables auto-advance and bit 12 requests a read. It reads back as written until a data commit advances the index.
- R4: An accepted data word, register select 1, low 10 bits, is stored at the current index in every table whose select bit is set.
- R5: With auto-advance set, each commit advances the index by one, and the index wraps from 255 to 0. With auto-advance clear, the index does not change.
- R6: After a data write is accepted, write-ready and address-ready are both low for exactly one cycle. A data write or an address write made during that cycle is ignored.
- R7: With correction disabled, each output colour equals its input shifted left by two.
- R8: With correction enabled, each output colour equals its own table's entry at the input value.
- R9: Read-ready is high when the read request bit is set and no commit is pending. Reading register select 1 returns the entry at the current index from the highest-priority selected table, in the order red, then green, then blue.
- R10: The output valid and the output colours follow an input pixel by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 address |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Register read value for reg_sel (combinational) |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_r_i | input | 8 | Input red |
| pix_g_i | input | 8 | Input green |
| pix_b_i | input | 8 | Input blue |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_r_o | output | 10 | Output red |
| pix_g_o | output | 10 | Output green |
| pix_b_o | output | 10 | Output blue |

## Verification
The index and ready-flag properties assume that no address write lands in the same cycle as a data commit. The block guarantees this by refusing address writes while a commit is pending, so the bench can also drive writes blindly into the busy cycle. The bypass property assumes correction stays off for the whole clock in which a pixel is sampled. The bench changes the enable bit only between pixel sweeps. Table loads are made while correction is off, and the read request is raised only during readback checks. The bench polls the ready flags before every ordinary write, so the only deliberate busy-cycle writes are the two that check the ignore rule.

// File: rtl/gamma_pkg.sv
// Shared constants for the gamma lookup block: register selects and
// control-word bit positions. Assumes three colour channels, red highest.
package gamma_pkg;
    localparam int          NCH       = 3;
    localparam logic [1:0]  RS_CTRL   = 2'd0;
    localparam logic [1:0]  RS_DATA   = 2'd1;
    localparam logic [1:0]  RS_ADDR   = 2'd2;
    localparam int          CB_EN     = 0;
    localparam int          CB_SET    = 1;
    localparam int          CB_TR     = 2;
    localparam int          CB_RDRDY  = 3;
    localparam int          CB_WRRDY  = 4;
    localparam int          CB_ADRRDY = 5;
endpackage

// File: rtl/gamma_chan_lut.sv
// One colour channel: a 2^IDX_W x VAL_W table written from the register
// port, a registered per-pixel lookup with bypass, and a combinational
// host read port. Assumes VAL_W >= IDX_W. The table itself is not reset.
module gamma_chan_lut #(
    parameter int IDX_W = 8,
    parameter int VAL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [VAL_W-1:0] wval,
    output logic [VAL_W-1:0] host_q,
    input  logic             lut_en,
    input  logic [IDX_W-1:0] pix_i,
    output logic [VAL_W-1:0] pix_o
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int PAD   = VAL_W - IDX_W;

    logic [VAL_W-1:0] mem [DEPTH];

    // Table write from the commit stage of the register port.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wval;
    end

    // Host readback of the entry at the current index.
    assign host_q = mem[idx];

    // Registered lookup, or widening bypass when correction is off.
    always_ff @(posedge clk) begin
        if (!rst_n)      pix_o <= '0;
        else if (lut_en) pix_o <= mem[pix_i];
        else             pix_o <= {pix_i, {PAD{1'b0}}};
    end

    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lut_en |=> pix_o == {$past(pix_i), {PAD{1'b0}}});
endmodule

// File: rtl/gamma_regport.sv
// Register port: control, address and data words, a one-cycle commit
// stage for data writes, index auto-advance and the ready flags.
// Assumes writes arrive as single-cycle strobes with reg_sel valid.
module gamma_regport
    import gamma_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int VAL_W = 10,
    parameter int REG_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [1:0]                reg_sel,
    input  logic [REG_W-1:0]          reg_wdata,
    output logic [REG_W-1:0]          reg_rdata,
    input  logic [NCH-1:0][VAL_W-1:0] host_q,
    output logic                      lut_en,
    output logic                      tbl_we,
    output logic [NCH-1:0]            tbl_sel,
    output logic [IDX_W-1:0]          tbl_idx,
    output logic [VAL_W-1:0]          tbl_wval
);
    localparam int SEL_LO   = IDX_W;
    localparam int AUTO_BIT = IDX_W + NCH;
    localparam int RD_BIT   = IDX_W + NCH + 1;

    logic             en_q, set_q, tr_q;
    logic [IDX_W-1:0] idx_q;
    logic [NCH-1:0]   sel_q;
    logic             auto_q, rdreq_q, pend_q;
    logic [VAL_W-1:0] wbuf_q;
    logic             wr_rdy, adr_rdy, rd_rdy;
    logic [VAL_W-1:0] host_pick;
    logic             unused_hi;

    assign wr_rdy    = !pend_q;
    assign adr_rdy   = !pend_q;
    assign rd_rdy    = rdreq_q && !pend_q;
    assign unused_hi = ^reg_wdata[REG_W-1:RD_BIT+1];

    // Register writes, commit stage and index advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            set_q   <= 1'b0;
            tr_q    <= 1'b0;
            idx_q   <= '0;
            sel_q   <= '0;
            auto_q  <= 1'b0;
            rdreq_q <= 1'b0;
            pend_q  <= 1'b0;
            wbuf_q  <= '0;
        end else begin
            pend_q <= 1'b0;
            if (pend_q && auto_q) idx_q <= idx_q + 1'b1;
            if (reg_wr) begin
                case (reg_sel)
                    RS_CTRL: begin
                        en_q  <= reg_wdata[CB_EN];
                        set_q <= reg_wdata[CB_SET];
                        tr_q  <= reg_wdata[CB_TR];
                    end
                    RS_DATA: if (wr_rdy) begin
                        pend_q <= 1'b1;
                        wbuf_q <= reg_wdata[VAL_W-1:0];
                    end
                    RS_ADDR: if (adr_rdy) begin
                        idx_q   <= reg_wdata[IDX_W-1:0];
                        sel_q   <= reg_wdata[SEL_LO +: NCH];
                        auto_q  <= reg_wdata[AUTO_BIT];
                        rdreq_q <= reg_wdata[RD_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Readback source: highest selected channel, red first.
    always_comb begin
        host_pick = '0;
        for (int c = 0; c < NCH; c++)
            if (sel_q[c]) host_pick = host_q[c];
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            RS_CTRL: begin
                reg_rdata[CB_EN]     = en_q;
                reg_rdata[CB_SET]    = set_q;
                reg_rdata[CB_TR]     = tr_q;
                reg_rdata[CB_RDRDY]  = rd_rdy;
                reg_rdata[CB_WRRDY]  = wr_rdy;
                reg_rdata[CB_ADRRDY] = adr_rdy;
            end
            RS_DATA: reg_rdata[VAL_W-1:0] = host_pick;
            RS_ADDR: begin
                reg_rdata[IDX_W-1:0]      = idx_q;
                reg_rdata[SEL_LO +: NCH]  = sel_q;
                reg_rdata[AUTO_BIT]       = auto_q;
                reg_rdata[RD_BIT]         = rdreq_q;
            end
            default: ;
        endcase
    end

    assign lut_en   = en_q;
    assign tbl_we   = pend_q;
    assign tbl_sel  = sel_q;
    assign tbl_idx  = idx_q;
    assign tbl_wval = wbuf_q;

    p_wr_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == RS_DATA && wr_rdy) |=> !wr_rdy);
    p_wr_recover_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rdy |=> wr_rdy);
    p_addr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == RS_ADDR && pend_q) |=> ($stable(sel_q) && $stable(auto_q)));
    p_idx_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && auto_q) |=> idx_q == IDX_W'($past(idx_q) + 1'b1));
    p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !auto_q) |=> $stable(idx_q));
endmodule

// File: rtl/gamma_lut_port.sv
// Top: register port plus one lookup table per colour channel. Pixels
// leave one clock after they enter. Tables are expected to be loaded
// with correction disabled.
module gamma_lut_port
    import gamma_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int VAL_W = 10,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             pix_vld_i,
    input  logic [IDX_W-1:0] pix_r_i,
    input  logic [IDX_W-1:0] pix_g_i,
    input  logic [IDX_W-1:0] pix_b_i,
    output logic             pix_vld_o,
    output logic [VAL_W-1:0] pix_r_o,
    output logic [VAL_W-1:0] pix_g_o,
    output logic [VAL_W-1:0] pix_b_o
);
    logic [NCH-1:0][VAL_W-1:0] host_q;
    logic [NCH-1:0][IDX_W-1:0] pix_in;
    logic [NCH-1:0][VAL_W-1:0] pix_out;
    logic                      lut_en, tbl_we;
    logic [NCH-1:0]            tbl_sel;
    logic [IDX_W-1:0]          tbl_idx;
    logic [VAL_W-1:0]          tbl_wval;

    assign pix_in = {pix_r_i, pix_g_i, pix_b_i};
    assign pix_r_o = pix_out[2];
    assign pix_g_o = pix_out[1];
    assign pix_b_o = pix_out[0];

    gamma_regport #(.IDX_W(IDX_W), .VAL_W(VAL_W), .REG_W(REG_W)) u_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_q(host_q),
        .lut_en(lut_en), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
        .tbl_idx(tbl_idx), .tbl_wval(tbl_wval)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        gamma_chan_lut #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_lut (
            .clk(clk), .rst_n(rst_n), .we(tbl_we && tbl_sel[c]),
            .idx(tbl_idx), .wval(tbl_wval), .host_q(host_q[c]),
            .lut_en(lut_en), .pix_i(pix_in[c]), .pix_o(pix_out[c])
        );
    end

    // Output valid tracks the lookup register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) pix_vld_o <= 1'b0;
        else        pix_vld_o <= pix_vld_i;
    end

    p_vld_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pix_vld_o == $past(pix_vld_i));
endmodule

// File: tb/sim_gamma_lut_port.sv
module sim_gamma_lut_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] S_CTRL = 2'd0, S_DATA = 2'd1, S_ADDR = 2'd2;

    logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, pix_vld_i = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic [7:0] pix_r_i = '0, pix_g_i = '0, pix_b_i = '0;
    logic pix_vld_o;
    logic [9:0] pix_r_o, pix_g_o, pix_b_o;

    int vecs = 0, fails = 0, b_idx = 0;
    int mdl [3][256];
    logic [2:0] b_sel = '0;
    logic b_auto = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gamma_lut_port u0 (.*);

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic rreg(input logic [1:0] s, output logic [15:0] v);
        @(negedge clk); reg_wr = 1'b0; reg_sel = s; #1; v = reg_rdata;
    endtask

    task automatic wreg(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic wait_flag(input int b);
        logic [15:0] v;
        for (int k = 0; k < 20; k++) begin
            rreg(S_CTRL, v);
            if (v[b]) return;
        end
        chk("R6 ready flag stuck", 0, 1);
    endtask

    task automatic put_addr(input int idx, input logic [2:0] sel, input logic au, input logic rd);
        wait_flag(5);
        wreg(S_ADDR, {3'b0, rd, au, sel, idx[7:0]});
        b_idx = idx; b_sel = sel; b_auto = au;
    endtask

    task automatic put_data(input int val);
        wait_flag(4);
        wreg(S_DATA, 16'(val));
        for (int c = 0; c < 3; c++) if (b_sel[c]) mdl[c][b_idx] = val;
        if (b_auto) b_idx = (b_idx + 1) % 256;
    endtask

    function automatic int fval(input int c, input int i);
        if (c == 2) return (i * 3 + 7) % 1024;
        if (c == 1) return 1023 - 4 * i;
        return (i * i) >> 6;
    endfunction

    function automatic int peek_exp(input logic [2:0] sel, input int idx);
        for (int c = 2; c >= 0; c--) if (sel[c]) return mdl[c][idx];
        return 0;
    endfunction

    task automatic peek(input string tag, input logic [2:0] sel, input int idx);
        logic [15:0] v;
        put_addr(idx, sel, 1'b0, 1'b1);
        rreg(S_DATA, v);
        chk(tag, v, peek_exp(sel, idx));
    endtask

    task automatic pix(input int r, input int g, input int b, input bit en, input bit vld);
        @(negedge clk);
        pix_vld_i = vld; pix_r_i = 8'(r); pix_g_i = 8'(g); pix_b_i = 8'(b);
        @(negedge clk);
        chk("R10 valid latency", pix_vld_o, vld);
        if (en) begin
            chk("R8 red lookup",   pix_r_o, mdl[2][r]);
            chk("R8 green lookup", pix_g_o, mdl[1][g]);
            chk("R8 blue lookup",  pix_b_o, mdl[0][b]);
        end else begin
            chk("R7 red bypass",   pix_r_o, r * 4);
            chk("R7 green bypass", pix_g_o, g * 4);
            chk("R7 blue bypass",  pix_b_o, b * 4);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rreg(S_CTRL, v); chk("R1 control after reset", v, 16'h0030);
        rreg(S_ADDR, v); chk("R1 address after reset", v, 0);
        chk("R1 valid after reset", pix_vld_o, 0);
        // R2 storage bits and read-only flags
        wreg(S_CTRL, 16'h003E);
        rreg(S_CTRL, v); chk("R2 control readback", v, 16'h0036);
        wreg(S_CTRL, 16'h0000);
        // R7 exhaustive bypass, R10 valid with gaps
        for (int i = 0; i < 256; i++) pix(i, 255 - i, i ^ 8'hA5, 1'b0, (i % 5) != 3);
        // R4 multi-select write into all three tables
        put_addr(0, 3'b111, 1'b1, 1'b0);
        for (int i = 0; i < 256; i++) put_data(i ^ 10'h2AA);
        for (int c = 0; c < 3; c++) peek("R4 multi-select entry", 3'(1 << c), 5);
        // R3/R5 per-channel loads, wrap to 0, then index 0x23
        for (int c = 2; c >= 0; c--) begin
            put_addr(0, 3'(1 << c), 1'b1, 1'b0);
            for (int i = 0; i < 256; i++) put_data(fval(c, i));
            rreg(S_ADDR, v); chk("R5 index wrapped after full load", v[7:0], 0);
            put_addr(8'h23, 3'(1 << c), 1'b1, 1'b0);
            rreg(S_ADDR, v); chk("R3 address readback", v, {8'h08 | (8'(1 << c)), 8'h23} & 16'h0FFF);
        end
        for (int i = 0; i < 256; i += 17) peek("R4 red entry", 3'b100, i);
        // R6 ready flags drop for one cycle after a data write
        put_addr(10, 3'b100, 1'b1, 1'b0);
        wait_flag(4);
        wreg(S_DATA, 16'h0155);
        #1; reg_sel = S_CTRL; #1;
        chk("R6 flags low in commit cycle", reg_rdata[5:4], 0);
        mdl[2][10] = 10'h155;
        rreg(S_CTRL, v); chk("R6 flags back next cycle", v[5:4], 2'b11);
        // R6 back-to-back data write is ignored
        @(negedge clk); reg_wr = 1'b1; reg_sel = S_DATA; reg_wdata = 16'h0077;
        @(negedge clk); reg_wdata = 16'h0088;
        @(negedge clk); reg_wr = 1'b0;
        mdl[2][11] = 10'h077;
        rreg(S_ADDR, v); chk("R6 index after ignored write", v[7:0], 12);
        peek("R6 accepted write", 3'b100, 11);
        peek("R6 ignored write left entry", 3'b100, 12);
        // R6 address write during commit is ignored
        put_addr(40, 3'b010, 1'b1, 1'b0);
        @(negedge clk); reg_wr = 1'b1; reg_sel = S_DATA; reg_wdata = 16'h0123;
        @(negedge clk); reg_sel = S_ADDR; reg_wdata = 16'h00C8;
        @(negedge clk); reg_wr = 1'b0;
        mdl[1][40] = 10'h123;
        rreg(S_ADDR, v); chk("R6 address write ignored", v, 16'h0A29);
        // R5 no auto-advance: index holds, last write wins
        put_addr(50, 3'b010, 1'b0, 1'b0);
        put_data(10'h0AB); put_data(10'h3CD);
        rreg(S_ADDR, v); chk("R5 index held", v[7:0], 50);
        peek("R5 last write wins", 3'b010, 50);
        // R5 explicit wrap from 255
        put_addr(255, 3'b001, 1'b1, 1'b0);
        put_data(10'h201);
        rreg(S_ADDR, v); chk("R5 wrap 255 to 0", v[7:0], 0);
        peek("R5 entry 255 written", 3'b001, 255);
        // R9 read flag and priority
        put_addr(7, 3'b101, 1'b0, 1'b1);
        rreg(S_CTRL, v); chk("R9 read-ready set", v[3], 1);
        rreg(S_DATA, v); chk("R9 red wins over blue", v, mdl[2][7]);
        put_addr(7, 3'b011, 1'b0, 1'b1);
        rreg(S_DATA, v); chk("R9 green wins over blue", v, mdl[1][7]);
        put_addr(7, 3'b011, 1'b0, 1'b0);
        rreg(S_CTRL, v); chk("R9 read-ready clear", v[3], 0);
        // R8 exhaustive lookup with correction on
        wreg(S_CTRL, 16'h0001);
        rreg(S_CTRL, v); chk("R2 enable set", v[0], 1);
        for (int i = 0; i < 256; i++) pix(i, i ^ 8'h5A, 255 - i, 1'b1, 1'b1);
        pix(3, 4, 5, 1'b1, 1'b0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule